// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a host-side SPI master for serial flash parts. Software drives it through a byte-addressed register window. It loads an opcode, a packed pair of byte counts and the outgoing payload bytes, then starts the command. The engine asserts chip select and shifts out the opcode. It then shifts out the payload bytes, clocks in the response and drops chip select again.

Payload and response share one 8-entry byte store. Outgoing bytes sit at the front of the store, and the response bytes are written behind them. One 3-bit pointer, visible to software, addresses the store for host accesses and for the engine. The pointer wraps modulo 8 and is cleared when a command starts. After a command, software clears the pointer and reads the store back through the data port. It can compare the pointer against the expected byte count to detect a corrupted transfer.

When a command carries no payload bytes, the byte captured while the opcode was shifting is kept as the first response byte. Software therefore programs the receive count one higher than the number of bytes it wants.

Top module: `sfc_engine`

## Requirements
- R1: After reset: `spi_cs_n` is 1, `spi_sck` is 0, the control byte (offset 0x2) reads 0x00, the count byte (offset 0x1) reads 0x00, and the status byte (offset 0xD) reads 0x30 (speed field 3, pointer 0).
- R2: A write to offset 0xC stores the byte at the store entry addressed by the pointer and advances the pointer. A read of offset 0xC returns the byte at the pointer and advances the pointer. The pointer reads in bits 2:0 of offset 0xD and wraps modulo 8.
- R3: At offset 0x2, writing 1 to bit 4 clears the pointer to 0, and writing 1 to bit 0 starts a command. Bit 0 reads 1 while a command runs and returns to 0 by itself when the command ends.
- R4: A command frame runs in SPI mode 0, MSB first. `spi_cs_n` falls before the first rising SCK edge, and SCK stays low whenever `spi_cs_n` is high. MOSI carries the opcode (offset 0x0), then store entries 0..T-1 in order, then 0x00 for every response byte.
- R5: Response bytes are written into the store after the T payload bytes, at successive pointer positions modulo 8. When the command ends, the pointer equals (T + R) mod 8.
- R6: When T is 0 and R is 1 or more, the frame is R bytes long. Store entry 0 receives the byte sampled on MISO during the opcode, and the remaining R-1 bytes follow it. In every other case the frame is 1 + T + R bytes long.
- R7: Offset 0x1 holds R in bits 7:4 and T in bits 3:0. It reads back exactly as written, also after a command has run.
- R8: Bits 5:4 of offset 0xD select the SCK period in system clocks: 1 gives 2, 2 gives 3, and 3 or 0 gives 4.
- R9: While a command runs, host writes to offsets 0x0, 0x1, 0xC and 0xD are ignored, writes to offset 0x2 are ignored, and reads of offset 0xC do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume the following about the inputs:
- `bus_wr` and `bus_rd` never assert in the same cycle.
- `spi_miso` is settled whenever the engine takes a sample.
- Reset is held low from time zero.

The bench issues each register access on the falling clock edge, one strobe at a time, with an idle cycle between accesses. Its flash model changes MISO only after the rising SCK edge at which the engine has already sampled. Payload counts are kept at 8 or fewer, so payload entries are never overwritten before they are sent. Response counts are chosen so that some commands wrap the store.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the serial flash command engine.
// Assumes a 4-bit byte offset into the register window.
package sfc_pkg;

    localparam logic [3:0] OFS_OPCODE = 4'h0;
    localparam logic [3:0] OFS_COUNT  = 4'h1;
    localparam logic [3:0] OFS_CTRL   = 4'h2;
    localparam logic [3:0] OFS_DATA   = 4'hC;
    localparam logic [3:0] OFS_STAT   = 4'hD;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_CLR_BIT = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    // Map the speed field to an SCK period in system clocks.
    function automatic logic [2:0] speed_to_div(input logic [1:0] sel);
        case (sel)
            2'd1:    return 3'd2;
            2'd2:    return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/sfc_fifo.sv
`timescale 1ns/1ps
// Byte store shared by payload and response data.
// One write port and one asynchronous read port, both indexed by the caller.
// Assumes the caller never needs two writes in one cycle.
module sfc_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store a byte, or clear every entry on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // Present the addressed entry.
    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/sfc_shifter.sv
`timescale 1ns/1ps
// SPI mode 0 byte shifter with an integer clock divider.
// A go pulse while idle starts one byte. SCK rises when the phase counter
// reaches LO-1, where MISO is sampled. SCK falls at DIV-1, where MOSI moves to
// the next bit. done pulses for one cycle after the eighth falling edge.
// Assumes div is 2 or more and stays constant during a byte.
module sfc_shifter #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 3,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic [DIV_W-1:0]  div,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);

    logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DIV_W-1:0]  ph_q;
    logic              active_q, sck_q, done_q;
    logic [DIV_W-1:0]  lo_len;

    // Length of the low part of an SCK period.
    assign lo_len = div - (div >> 1);

    // Run the phase counter and shift the data on SCK edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh_q  <= '0;
            rx_sh_q  <= '0;
            bit_q    <= '0;
            ph_q     <= '0;
            active_q <= 1'b0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !active_q) begin
                tx_sh_q  <= tx_byte;
                bit_q    <= '0;
                ph_q     <= '0;
                active_q <= 1'b1;
            end else if (active_q) begin
                if (ph_q == lo_len - 1'b1) begin
                    sck_q   <= 1'b1;
                    rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
                end
                if (ph_q == div - 1'b1) begin
                    sck_q   <= 1'b0;
                    ph_q    <= '0;
                    tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                    if (bit_q == BIT_W'(DATA_W - 1)) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = tx_sh_q[DATA_W-1];
    assign done    = done_q;
    assign rx_byte = rx_sh_q;

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> !sck_q);                                   // R4
    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !active_q);                                        // R4
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && sck_q) |-> $stable(tx_sh_q[DATA_W-1]));     // R4

endmodule

// File: rtl/sfc_engine.sv
`timescale 1ns/1ps
// Serial flash command engine: register window, shared byte store pointer,
// and the command sequencer that drives the byte shifter.
// Frame: opcode, then T payload bytes from the store, then response bytes
// written behind them. With T = 0 and R > 0, the byte sampled during the
// opcode counts as the first response byte.
// Assumes bus_wr and bus_rd never assert in the same cycle.
module sfc_engine #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 4,
    parameter int ADDR_W     = 4,
    localparam int PTR_W     = $clog2(FIFO_DEPTH),
    localparam int IDX_W     = CNT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    import sfc_pkg::*;

    logic [DATA_W-1:0] opcode_q;
    logic [CNT_W-1:0]  rxcnt_q, txcnt_q;
    logic [1:0]        speed_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              busy_q, cs_n_q;
    seq_state_e        state_q;
    logic [IDX_W-1:0]  bidx_q, total_q;

    logic              host_wr_ok, go_cmd, clr_ptr, host_push, host_pop;
    logic              eng_fetch, eng_store, quirk;
    logic              sh_go, sh_done;
    logic [DATA_W-1:0] sh_tx, sh_rx, fifo_rd;
    logic [CNT_W:0]    cnt_sum;
    logic [IDX_W-1:0]  total_calc, tx_idx;

    // Decode host accesses; all register updates are blocked while busy.
    assign host_wr_ok = bus_wr && !busy_q;
    assign go_cmd     = host_wr_ok && bus_addr == OFS_CTRL && bus_wdata[CTRL_GO_BIT];
    assign clr_ptr    = host_wr_ok && bus_addr == OFS_CTRL && bus_wdata[CTRL_CLR_BIT];
    assign host_push  = host_wr_ok && bus_addr == OFS_DATA;
    assign host_pop   = bus_rd && !busy_q && bus_addr == OFS_DATA;

    // Frame length: opcode + payload + response, one less in the no-payload case.
    assign quirk      = (txcnt_q == '0) && (rxcnt_q != '0);
    assign cnt_sum    = {1'b0, txcnt_q} + {1'b0, rxcnt_q};
    assign total_calc = IDX_W'(cnt_sum) + IDX_W'(1) - IDX_W'(quirk);
    assign tx_idx     = IDX_W'(txcnt_q);

    // Sequencer-side store accesses.
    assign eng_fetch = (state_q == SEQ_ISSUE) && (bidx_q != '0) && (bidx_q <= tx_idx);
    assign eng_store = (state_q == SEQ_WAIT) && sh_done && ((bidx_q > tx_idx) || quirk);

    // Byte sent for the current frame position.
    always_comb begin
        if (bidx_q == '0) begin
            sh_tx = opcode_q;
        end else if (bidx_q <= tx_idx) begin
            sh_tx = fifo_rd;
        end else begin
            sh_tx = '0;
        end
    end
    assign sh_go = (state_q == SEQ_ISSUE);

    // Host-programmed opcode, counts and speed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_q <= '0;
            rxcnt_q  <= '0;
            txcnt_q  <= '0;
            speed_q  <= 2'd3;
        end else if (host_wr_ok) begin
            case (bus_addr)
                OFS_OPCODE: opcode_q <= bus_wdata;
                OFS_COUNT:  {rxcnt_q, txcnt_q} <= bus_wdata[2*CNT_W-1:0];
                OFS_STAT:   speed_q <= bus_wdata[5:4];
                default:    ;
            endcase
        end
    end

    // Shared store pointer: cleared on start or request, stepped on every access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (go_cmd || clr_ptr) begin
            ptr_q <= '0;
        end else if (host_push || host_pop || eng_fetch || eng_store) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // Command sequencer: chip select, byte issue and frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            busy_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            bidx_q  <= '0;
            total_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (go_cmd) begin
                        busy_q  <= 1'b1;
                        cs_n_q  <= 1'b0;
                        bidx_q  <= '0;
                        total_q <= total_calc;
                        state_q <= SEQ_ISSUE;
                    end
                end
                SEQ_ISSUE: state_q <= SEQ_WAIT;
                SEQ_WAIT: begin
                    if (sh_done) begin
                        if (bidx_q == total_q - 1'b1) begin
                            busy_q  <= 1'b0;
                            cs_n_q  <= 1'b1;
                            state_q <= SEQ_IDLE;
                        end else begin
                            bidx_q  <= bidx_q + 1'b1;
                            state_q <= SEQ_ISSUE;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    sfc_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_push || eng_store),
        .wr_idx  (ptr_q),
        .wr_data (busy_q ? sh_rx : bus_wdata),
        .rd_idx  (ptr_q),
        .rd_data (fifo_rd)
    );

    sfc_shifter #(.DATA_W(DATA_W), .DIV_W(3)) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (sh_go),
        .tx_byte (sh_tx),
        .div     (speed_to_div(speed_q)),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_OPCODE: bus_rdata = opcode_q;
            OFS_COUNT:  bus_rdata[2*CNT_W-1:0] = {rxcnt_q, txcnt_q};
            OFS_CTRL:   bus_rdata[CTRL_GO_BIT] = busy_q;
            OFS_DATA:   bus_rdata = fifo_rd;
            OFS_STAT: begin
                bus_rdata[5:4]       = speed_q;
                bus_rdata[PTR_W-1:0] = ptr_q;
            end
            default:    bus_rdata = '0;
        endcase
    end

    assign spi_cs_n = cs_n_q;

    AST_CS_QUIET_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);                                            // R4
    AST_PTR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (ptr_q == cnt_sum[PTR_W-1:0]));                  // R5
    AST_PTR_CLEAR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> (ptr_q == '0));                                  // R3
    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable({rxcnt_q, txcnt_q}));       // R7
    AST_SPEED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(speed_q));                   // R9

endmodule

// File: tb/sfc_engine_tb_top.sv
`timescale 1ns/1ps
module sfc_engine_tb_top;
    import sfc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic       spi_cs_n, spi_sck, spi_mosi, spi_miso;

    always #5 clk = ~clk;

    sfc_engine dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    // ---------------- flash model ----------------
    logic [4:0] sbyte = '0;
    logic [2:0] sbit = '0;
    logic [7:0] mshift = '0;
    logic [7:0] mosi_log [32];
    realtime    rise0, rise1;
    int         rises = 0;
    logic [7:0] cur_resp;

    function automatic logic [7:0] slv_byte(input logic [4:0] k);
        return 8'h3C ^ ({3'b000, k} * 8'd37);
    endfunction

    always_comb cur_resp = slv_byte(sbyte);
    assign spi_miso = cur_resp[3'd7 - sbit];

    always @(negedge spi_cs_n) begin
        sbyte = '0;
        sbit  = '0;
        rises = 0;
    end

    always @(posedge spi_sck) begin
        logic [7:0] nb;
        if (rises == 0) rise0 = $realtime;
        if (rises == 1) rise1 = $realtime;
        rises++;
        nb = {mshift[6:0], spi_mosi};
        mshift = nb;
        if (sbit == 3'd7) begin
            mosi_log[sbyte] = nb;
            sbyte = sbyte + 1'b1;
        end
        sbit = sbit + 1'b1;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        int n = 0;
        do begin
            bus_read(OFS_CTRL, v);
            n++;
        end while (v[0] && n < 5000);
    endtask

    logic [7:0] expf [8];

    // Vector: {speed, opcode, tx count, rx count}
    localparam int NVEC = 6;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd1, 8'h9F, 8'd0, 8'd4},
        {8'd2, 8'h03, 8'd3, 8'd2},
        {8'd3, 8'h05, 8'd0, 8'd0},
        {8'd0, 8'h0B, 8'd4, 8'd1},
        {8'd1, 8'h02, 8'd3, 8'd7},
        {8'd2, 8'h5A, 8'd8, 8'd0}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // ---- R1 reset state ----
        chk("R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
        chk("R1 sck", {31'd0, spi_sck}, 32'd0);
        bus_read(OFS_CTRL, rd);  chk("R1 ctrl", {24'd0, rd}, 32'h00);
        bus_read(OFS_COUNT, rd); chk("R1 count", {24'd0, rd}, 32'h00);
        bus_read(OFS_STAT, rd);  chk("R1 stat", {24'd0, rd}, 32'h30);

        // ---- R2 FIFO port and wrap ----
        for (int i = 0; i < 9; i++) begin
            bus_write(OFS_DATA, 8'hD0 + 8'(i));
            expf[i % 8] = 8'hD0 + 8'(i);
        end
        bus_read(OFS_STAT, rd); chk("R2 pointer wraps after 9 writes", {29'd0, rd[2:0]}, 32'd1);
        bus_write(OFS_CTRL, 8'h10);
        bus_read(OFS_STAT, rd); chk("R3 pointer clear", {29'd0, rd[2:0]}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            bus_read(OFS_DATA, rd);
            chk("R2 data port read", {24'd0, rd}, {24'd0, expf[i]});
        end
        bus_read(OFS_STAT, rd); chk("R2 pointer after 8 reads", {29'd0, rd[2:0]}, 32'd0);

        // ---- vector walk: R4 R5 R6 R7 R8 ----
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] spd;
            logic [7:0] op;
            int tx, rx, total, slot, per, nexp;
            bit qk;
            spd = VEC[v][25:24];
            op  = VEC[v][23:16];
            tx  = int'(VEC[v][15:8]);
            rx  = int'(VEC[v][7:0]);
            qk  = (tx == 0) && (rx > 0);
            total = 1 + tx + rx - (qk ? 1 : 0);
            per = (spd == 2'd1) ? 20 : (spd == 2'd2) ? 30 : 40;

            bus_write(OFS_STAT, {2'b00, spd, 4'h0});
            bus_write(OFS_OPCODE, op);
            bus_write(OFS_COUNT, {VEC[v][3:0], VEC[v][11:8]});
            bus_write(OFS_CTRL, 8'h10);
            for (int i = 0; i < tx; i++) begin
                bus_write(OFS_DATA, 8'h60 + 8'(v * 16 + i));
                expf[i % 8] = 8'h60 + 8'(v * 16 + i);
            end
            bus_write(OFS_CTRL, 8'h10);
            bus_write(OFS_CTRL, 8'h01);
            wait_idle();

            chk("R4 R6 frame length", {27'd0, sbyte}, 32'(total));
            chk("R4 opcode on MOSI", {24'd0, mosi_log[0]}, {24'd0, op});
            for (int i = 0; i < tx; i++)
                chk("R4 payload on MOSI", {24'd0, mosi_log[1 + i]}, {24'd0, 8'h60 + 8'(v * 16 + i)});
            if (!qk && rx > 0)
                chk("R4 zero MOSI in response", {24'd0, mosi_log[1 + tx]}, 32'd0);
            chk("R8 sck period ns", 32'(int'(rise1 - rise0)), 32'(per));
            bus_read(OFS_STAT, rd);
            chk("R5 final pointer", {29'd0, rd[2:0]}, 32'((tx + rx) % 8));
            chk("R8 speed readback", {30'd0, rd[5:4]}, {30'd0, spd});
            bus_read(OFS_COUNT, rd);
            chk("R7 count readback", {24'd0, rd}, {24'd0, VEC[v][3:0], VEC[v][11:8]});

            slot = tx;
            for (int k = 0; k < total; k++) begin
                if (k > tx || qk) begin
                    expf[slot % 8] = slv_byte(5'(k));
                    slot++;
                end
            end
            bus_write(OFS_CTRL, 8'h10);
            nexp = (tx + rx > 8) ? 8 : tx + rx;
            for (int i = 0; i < nexp; i++) begin
                bus_read(OFS_DATA, rd);
                chk(qk ? "R6 store after no-payload frame" : "R5 store contents",
                    {24'd0, rd}, {24'd0, expf[i]});
            end
        end

        // ---- R3 / R9 busy behaviour ----
        bus_write(OFS_STAT, 8'h30);
        bus_write(OFS_OPCODE, 8'hC7);
        bus_write(OFS_COUNT, 8'hF0);
        bus_write(OFS_CTRL, 8'h01);
        bus_read(OFS_CTRL, rd);   chk("R3 busy bit set", {31'd0, rd[0]}, 32'd1);
        chk("R4 cs_n low while busy", {31'd0, spi_cs_n}, 32'd0);
        bus_write(OFS_COUNT, 8'hFF);
        bus_write(OFS_OPCODE, 8'hEE);
        bus_write(OFS_STAT, 8'h10);
        bus_write(OFS_DATA, 8'h77);
        bus_write(OFS_CTRL, 8'h10);
        bus_read(OFS_DATA, rd);
        wait_idle();
        bus_read(OFS_CTRL, rd);   chk("R3 busy bit self-clears", {31'd0, rd[0]}, 32'd0);
        bus_read(OFS_COUNT, rd);  chk("R9 count write ignored", {24'd0, rd}, 32'hF0);
        bus_read(OFS_OPCODE, rd); chk("R9 opcode write ignored", {24'd0, rd}, 32'hC7);
        bus_read(OFS_STAT, rd);
        chk("R9 speed write ignored", {30'd0, rd[5:4]}, 32'd3);
        chk("R9 pointer untouched by busy accesses", {29'd0, rd[2:0]}, 32'd7);
        chk("R6 15-byte frame for rx 15 no payload", {27'd0, sbyte}, 32'd15);
        chk("R4 opcode of long frame", {24'd0, mosi_log[0]}, 32'hC7);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule